// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces one pulse-width-modulated output from an 8-bit period timer. A 2-bit sub-count sits below the timer so that the duty comparison runs against a 10-bit time base. The input clock first passes a prescaler that divides by 1, 4 or 16. The timer then advances once every four prescaled ticks. The sub-count is the position within those four ticks.

Software may write the duty value at any moment through two buffer registers: an 8-bit upper part and a 2-bit lower part. The timer restarts when it reaches the programmed period. At that same edge the buffered value is copied into a slave duty register, and only the slave register drives the comparison. A new duty value therefore never shortens or stretches a cycle that is already in progress. The slave register can be read back on a port. When the block is disabled, the output is low and all of its counting state is cleared.

Top module: `dbuf_pwm_gen`

## Requirements
- R1: While `enable` is low, `pwm_out` is 0 and `duty_active` is 0 from the next clock on, and the prescaler, sub-count and timer are held at zero.
- R2: With `enable` high, each PWM cycle lasts (period + 1) × 4 × S input clocks, where S is the prescale. `presc_sel` 2'b00 gives S=1, 2'b01 gives S=4, and 2'b10 or 2'b11 gives S=16.
- R3: At each period boundary, `pwm_out` goes high on the same edge that loads the slave register, provided the newly loaded duty value is nonzero.
- R4: When the loaded duty D lies in the range 1 to 4 × period + 3, `pwm_out` stays high for exactly D × S input clocks of the cycle and is low for the rest of it.
- R5: Writes to the duty buffers leave `duty_active` unchanged until the next period boundary. At that boundary `duty_active` takes the buffered value.
- R6: The loaded duty value is {upper, lower}: `duty_hi_data` supplies bits 9:2 and `duty_lo_data` supplies bits 1:0.
- R7: A loaded duty value greater than 4 × period + 3 holds `pwm_out` high for the entire cycle.
- R8: A loaded duty value of zero gives no high pulse at all. `pwm_out` stays low for the whole cycle, boundary included.
- R9: Each of the two duty buffers is written only by its own write strobe. Writing the upper part keeps the previously written lower part.
- R10: After `enable` rises, `duty_active` reads 0 and `pwm_out` stays low until the first period boundary, which falls (period + 1) × 4 × S clocks after the enabling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the generator when high; clears it when low |
| presc_sel | input | 2 | Prescale select: 00 = 1, 01 = 4, 1x = 16 |
| period | input | 8 | Timer value at which the cycle ends |
| duty_hi_wr | input | 1 | Write strobe for the upper duty buffer |
| duty_hi_data | input | 8 | Upper 8 bits of the duty value |
| duty_lo_wr | input | 1 | Write strobe for the lower duty buffer |
| duty_lo_data | input | 2 | Lower 2 bits of the duty value |
| duty_active | output | 10 | Readback of the slave duty register |
| pwm_out | output | 1 | PWM output |

## Verification
If the prescaler or timer holds a wrong count, the slave readback changes at the wrong clock. That error appears within one PWM cycle of enabling, because the first load is checked on the exact clock the period formula predicts. A wrong time base or compare shows up in the same cycle as a high time that differs from D × S. If the buffering is broken, the readback changes outside a boundary, or the lower bits are lost when only the upper part is rewritten. Either fault is visible at the next boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned TMR_W   = 8;
  localparam int unsigned SUB_W   = 2;
  localparam int unsigned DUTY_W  = TMR_W + SUB_W;
  localparam int unsigned SHIFT_MAX = 4;
  localparam int unsigned CNT_W   = SUB_W + SHIFT_MAX;

  typedef enum logic [1:0] {
    PS_DIV1  = 2'b00,
    PS_DIV4  = 2'b01,
    PS_DIV16 = 2'b10,
    PS_DIV16B = 2'b11
  } presc_e;

  // log2 of the prescale ratio
  function automatic logic [2:0] presc_shift(input logic [1:0] sel);
    case (sel)
      2'b00:   presc_shift = 3'd0;
      2'b01:   presc_shift = 3'd2;
      default: presc_shift = 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_pkg::*;
#(
  parameter int unsigned SW = SUB_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [1:0]    sel,
  output logic          tick,
  output logic [SW-1:0] sub_nxt
);
  logic [CW-1:0] cnt_q, cnt_d, cnt_max, cnt_shr;
  logic [2:0]    shift;

  always_comb begin
    shift   = presc_shift(sel);
    cnt_max = CW'((CW'(1) << (SW + shift)) - 1);
    tick    = en && (cnt_q >= cnt_max);
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
    cnt_shr = cnt_d >> shift;
    sub_nxt = cnt_shr[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TICK_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int unsigned TW = TMR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic [TW-1:0] period,
  output logic          boundary,
  output logic [TW-1:0] tmr_nxt
);
  logic [TW-1:0] tmr_q;

  always_comb begin
    boundary = tick && (tmr_q == period);
    if (!en)           tmr_nxt = '0;
    else if (boundary) tmr_nxt = '0;
    else if (tick)     tmr_nxt = tmr_q + TW'(1);
    else               tmr_nxt = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_nxt;
  end

  AST_TMR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (tmr_q == '0)); // R2
  AST_TMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tmr_q == '0)); // R1
endmodule

// File: rtl/pwm_duty_buffer.sv
module pwm_duty_buffer
  import pwm_pkg::*;
#(
  parameter int unsigned HW = TMR_W,
  parameter int unsigned LW = SUB_W,
  localparam int unsigned DW = HW + LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          boundary,
  input  logic          hi_wr,
  input  logic [HW-1:0] hi_data,
  input  logic          lo_wr,
  input  logic [LW-1:0] lo_data,
  output logic [DW-1:0] master,
  output logic [DW-1:0] slave
);
  logic [HW-1:0] hi_q, hi_d;
  logic [LW-1:0] lo_q, lo_d;
  logic [DW-1:0] slave_q, slave_d;

  always_comb begin
    hi_d = hi_wr ? hi_data : hi_q;
    lo_d = lo_wr ? lo_data : lo_q;
    master = {hi_q, lo_q};
    if (!en)           slave_d = '0;
    else if (boundary) slave_d = master;
    else               slave_d = slave_q;
    slave = slave_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      slave_q <= '0;
    end else begin
      hi_q    <= hi_d;
      lo_q    <= lo_d;
      slave_q <= slave_d;
    end
  end

  AST_SLAVE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (slave_q == $past({hi_q, lo_q}))); // R6
  AST_SLAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !boundary) |=> $stable(slave_q)); // R5
endmodule

// File: rtl/dbuf_pwm_gen.sv
module dbuf_pwm_gen
  import pwm_pkg::*;
#(
  parameter int unsigned TW = TMR_W,
  parameter int unsigned SW = SUB_W,
  localparam int unsigned DW = TW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic [1:0]    presc_sel,
  input  logic [TW-1:0] period,
  input  logic          duty_hi_wr,
  input  logic [TW-1:0] duty_hi_data,
  input  logic          duty_lo_wr,
  input  logic [SW-1:0] duty_lo_data,
  output logic [DW-1:0] duty_active,
  output logic          pwm_out
);
  logic [1:0]    rst_sync_q;
  logic          rst_ns;
  logic          tick, boundary;
  logic [SW-1:0] sub_nxt;
  logic [TW-1:0] tmr_nxt;
  logic [DW-1:0] master, slave;
  logic [DW-1:0] base_nxt;
  logic          pwm_q, pwm_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ns = rst_sync_q[1];

  pwm_prescaler #(.SW(SW), .CW(SW + SHIFT_MAX)) u_presc (
    .clk(clk), .rst_n(rst_ns), .en(enable), .sel(presc_sel),
    .tick(tick), .sub_nxt(sub_nxt)
  );

  pwm_timebase #(.TW(TW)) u_tbase (
    .clk(clk), .rst_n(rst_ns), .en(enable), .tick(tick), .period(period),
    .boundary(boundary), .tmr_nxt(tmr_nxt)
  );

  pwm_duty_buffer #(.HW(TW), .LW(SW)) u_dbuf (
    .clk(clk), .rst_n(rst_ns), .en(enable), .boundary(boundary),
    .hi_wr(duty_hi_wr), .hi_data(duty_hi_data),
    .lo_wr(duty_lo_wr), .lo_data(duty_lo_data),
    .master(master), .slave(slave)
  );

  // compare against the time base the next edge will produce, so the
  // high time is exactly duty x prescale clocks
  always_comb begin
    base_nxt = {tmr_nxt, sub_nxt};
    if (!enable)                pwm_d = 1'b0;
    else if (boundary)          pwm_d = (master != '0);
    else if (base_nxt == slave) pwm_d = 1'b0;
    else                        pwm_d = pwm_q;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) pwm_q <= 1'b0;
    else         pwm_q <= pwm_d;
  end

  assign pwm_out     = pwm_q;
  assign duty_active = slave;

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_ns)
    !enable |=> (!pwm_out && duty_active == '0)); // R1
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_ns)
    (duty_active == '0) |-> !pwm_out); // R8
  AST_RISE_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(pwm_out) |-> $past(boundary)); // R3
endmodule

// File: tb/dbuf_pwm_gen_test.sv
module dbuf_pwm_gen_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       enable;
  logic [1:0] presc_sel;
  logic [7:0] period;
  logic       duty_hi_wr;
  logic [7:0] duty_hi_data;
  logic       duty_lo_wr;
  logic [1:0] duty_lo_data;
  logic [9:0] duty_active;
  logic       pwm_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  dbuf_pwm_gen uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .presc_sel(presc_sel),
    .period(period), .duty_hi_wr(duty_hi_wr), .duty_hi_data(duty_hi_data),
    .duty_lo_wr(duty_lo_wr), .duty_lo_data(duty_lo_data),
    .duty_active(duty_active), .pwm_out(pwm_out)
  );

  function automatic int f_scale(input logic [1:0] sel);
    return (sel == 2'b00) ? 1 : (sel == 2'b01) ? 4 : 16;
  endfunction

  function automatic int f_cycle(input logic [7:0] per, input logic [1:0] sel);
    return (int'(per) + 1) * 4 * f_scale(sel);
  endfunction

  function automatic int f_high(input logic [9:0] d, input logic [7:0] per,
                                input logic [1:0] sel);
    if (d == 0) return 0;
    if (int'(d) > 4 * int'(per) + 3) return f_cycle(per, sel);
    return int'(d) * f_scale(sel);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_case(input logic [1:0] sel, input logic [7:0] per,
                          input logic [9:0] d1, input logic [9:0] d2,
                          input bit hi_only);
    int m, hi_cnt;
    logic [9:0] d_next;
    m = f_cycle(per, sel);
    d_next = hi_only ? {d2[9:2], d1[1:0]} : d2;
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(pwm_out == 1'b0 && duty_active == 10'd0, "R1 disabled state",
          int'(duty_active) + (pwm_out ? 2048 : 0), 0);
    presc_sel = sel;
    period = per;
    duty_hi_wr = 1'b1; duty_hi_data = d1[9:2];
    @(negedge clk);
    duty_hi_wr = 1'b0;
    duty_lo_wr = 1'b1; duty_lo_data = d1[1:0];
    @(negedge clk);
    duty_lo_wr = 1'b0;
    enable = 1'b1;
    hi_cnt = 0;
    for (int i = 0; i < m - 1; i++) begin
      @(negedge clk);
      if (pwm_out) hi_cnt++;
      if (i == m - 2)
        check(duty_active == 10'd0, "R10 no load before first boundary",
              int'(duty_active), 0);
    end
    check(hi_cnt == 0, "R10 low before first boundary", hi_cnt, 0);
    hi_cnt = 0;
    for (int j = 0; j < m; j++) begin
      @(negedge clk);
      if (j == 0) begin
        check(duty_active == d1, "R2 R6 load at boundary", int'(duty_active), int'(d1));
        if (d1 != 0) check(pwm_out == 1'b1, "R3 high at boundary", int'(pwm_out), 1);
        duty_hi_wr = 1'b1; duty_hi_data = d2[9:2];
      end
      if (j == 1) begin
        duty_hi_wr = 1'b0;
        if (!hi_only) begin duty_lo_wr = 1'b1; duty_lo_data = d2[1:0]; end
      end
      if (j == 2) duty_lo_wr = 1'b0;
      if (pwm_out) hi_cnt++;
      if (j == m - 1)
        check(duty_active == d1, "R5 held until boundary", int'(duty_active), int'(d1));
    end
    if (d1 == 0)
      check(hi_cnt == 0, "R8 zero duty no pulse", hi_cnt, 0);
    else if (int'(d1) > 4 * int'(per) + 3)
      check(hi_cnt == m, "R7 duty beyond period", hi_cnt, m);
    else
      check(hi_cnt == f_high(d1, per, sel), "R4 high time", hi_cnt, f_high(d1, per, sel));
    @(negedge clk);
    check(duty_active == d_next, hi_only ? "R9 upper-only write" : "R5 new duty loaded",
          int'(duty_active), int'(d_next));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    rst_n = 1'b0; enable = 1'b0; presc_sel = 2'b00; period = 8'd0;
    duty_hi_wr = 1'b0; duty_hi_data = 8'd0; duty_lo_wr = 1'b0; duty_lo_data = 2'd0;
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0 && duty_active == 10'd0, "R1 reset state",
          int'(duty_active) + (pwm_out ? 2048 : 0), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // directed corners
    run_case(2'b00, 8'd0,   10'd2,    10'd1,   1'b0);
    run_case(2'b00, 8'd10,  10'd0,    10'd5,   1'b0);
    run_case(2'b00, 8'd10,  10'd1023, 10'd43,  1'b0);
    run_case(2'b01, 8'd10,  10'd43,   10'd200, 1'b1);
    run_case(2'b10, 8'd255, 10'd512,  10'd7,   1'b0);
    run_case(2'b01, 8'd255, 10'd1023, 10'd0,   1'b0);
    run_case(2'b11, 8'd3,   10'd15,   10'd16,  1'b1);
    // random mix
    for (int k = 0; k < 12; k++) begin
      logic [1:0] s;
      logic [7:0] p;
      logic [9:0] a, b;
      s = 2'($urandom_range(0, 3));
      p = (s[1]) ? 8'($urandom_range(0, 40)) : 8'($urandom_range(0, 255));
      a = 10'($urandom_range(0, 4 * int'(p) + 8));
      b = 10'($urandom);
      run_case(s, p, a, b, k[0]);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule